// File: doc/BRIEF.md
# Write-allocate cache with zero-fill installation for dead memory

This block is a small set-associative, write-back, write-allocate cache controller. It sits between one requester and a line-wide memory port. A companion range tracker knows which address ranges hold no live data: memory that is allocated but not yet initialised, or objects already found dead. The controller asks the tracker about lines through a combinational lookup port and uses the answer in three places. A store that misses on a dead line is built from zeros in place and never reads memory. A dirty victim whose line is dead is discarded instead of written back. When a set is full, dead lines are replaced before live ones.

The controller serves one request at a time. A miss holds off the requester until the line is in place. The victim checks, one way per cycle, run while the memory read is outstanding, so they do not lengthen a normal refill. When a store is installed on a zero-filled line, the controller also reports that line address on a separate output. The tracker can use it to shrink the dead range.

Top module: `alloc_llc`

## Requirements
- R1: After reset the cache holds no valid line, `cpu_ready` is 1, and neither `mem_valid` nor `cpu_rvalid` is asserted.
- R2: A load that hits returns the stored word, one response per request, with no memory request.
- R3: A store that hits merges its bytes into the word: `cpu_be` bit i selects byte i, bits [8i+7:8i] of `cpu_wdata`. The other bytes keep their old value.
- R4: A store miss whose line address the tracker reports dead issues no memory read. The line becomes all zeros with the store bytes merged in, and is valid and dirty.
- R5: A store miss on a live line reads the line from memory first, then merges the store bytes. The words that were not written keep their memory value.
- R6: A load miss always reads the line from memory, whether or not the line is in a dead range.
- R7: Replacing a dirty line that is not dead writes the whole line to memory at that line's address (`mem_we` = 1). Replacing a clean line writes nothing.
- R8: Replacing a dirty line that the tracker reports dead writes nothing to memory.
- R9: The victim is chosen in this order: an empty way first, then any way whose line is dead, then a per-set round-robin pointer. The pointer moves to the way after each victim.
- R10: From the cycle a request is accepted until its response, `cpu_ready` is 0.
- R11: A memory request keeps `mem_valid`, `mem_we` and `mem_addr` stable until `mem_ready` is seen.
- R12: An installing store pulses `rng_st_valid` for one cycle with the installed line address, in the same cycle as its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Controller idle and able to accept |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_rvalid | output | 1 | Response for the current request (loads and stores) |
| cpu_rdata | output | DATA_W | Load data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wdata | output | WORDS*DATA_W | Write-back line |
| mem_rvalid | input | 1 | Read data returning |
| mem_rdata | input | WORDS*DATA_W | Read line |
| rng_qvalid | output | 1 | Tracker lookup valid |
| rng_qaddr | output | ADDR_W-OFF_W | Line address looked up |
| rng_qhit | input | 1 | Same-cycle answer: line is dead |
| rng_st_valid | output | 1 | Installing store notification |
| rng_st_addr | output | ADDR_W-OFF_W | Line address of the installing store |

## Verification
The checks assume the tracker answers in the same cycle and that its ranges do not change while a miss is in progress. They also assume memory sends exactly one read reply per accepted read and never an unrequested one. The bench changes the dead range only between requests, when the controller is idle. Its memory model accepts with a gapped ready pattern and replies a fixed number of cycles after each accepted read, so the hold-until-ready rule is exercised without ever breaking the one-reply rule.

// File: rtl/alloc_llc_pkg.sv
package alloc_llc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RDREQ,
        ST_RDWAIT,
        ST_CHECK,
        ST_WB,
        ST_FILL
    } llc_state_e;

    // index width that stays at least one bit for a single-entry dimension
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/alloc_llc_merge.sv
module alloc_llc_merge #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int WIDX_W = 2,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [WORDS*DATA_W-1:0] base,
    input  logic                    en,
    input  logic [WIDX_W-1:0]       widx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [BYTES-1:0]        be,
    output logic [WORDS*DATA_W-1:0] merged
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign merged[w*DATA_W + 8*b +: 8] =
                (en && widx == WIDX_W'(w) && be[b]) ? wdata[8*b +: 8]
                                                     : base[w*DATA_W + 8*b +: 8];
        end
    end
endmodule

// File: rtl/alloc_llc_victim.sv
module alloc_llc_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  line_ok,
    input  logic [WAYS-1:0]  dead,
    input  logic [WAY_W-1:0] start,
    output logic [WAY_W-1:0] pick
);
    logic [WAYS-1:0] cand;
    logic            found;
    logic [WAY_W-1:0] idx;

    always_comb begin
        if (|(~line_ok))  cand = ~line_ok;
        else if (|dead)   cand = dead;
        else              cand = '1;
        pick  = start;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < WAYS; k++) begin
            idx = WAY_W'((int'(start) + k) % WAYS);
            if (!found && cand[idx]) begin
                pick  = idx;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/alloc_llc.sv
module alloc_llc
    import alloc_llc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    localparam int BYTES  = DATA_W / 8,
    localparam int BOFF_W = $clog2(BYTES),
    localparam int WIDX_W = idx_w(WORDS),
    localparam int OFF_W  = BOFF_W + $clog2(WORDS),
    localparam int SET_W  = idx_w(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int LA_W   = ADDR_W - OFF_W,
    localparam int LINE_W = WORDS * DATA_W,
    localparam int WAY_W  = idx_w(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BYTES-1:0]  cpu_be,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [LA_W-1:0]   mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [LINE_W-1:0] mem_rdata,
    output logic              rng_qvalid,
    output logic [LA_W-1:0]   rng_qaddr,
    input  logic              rng_qhit,
    output logic              rng_st_valid,
    output logic [LA_W-1:0]   rng_st_addr
);
    typedef struct packed {
        logic              we;
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [WIDX_W-1:0] widx;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  be;
    } req_t;

    llc_state_e        st_q;
    req_t              rq;
    logic              install_q;
    logic [WAY_W:0]    chk_cnt_q;
    logic [WAYS-1:0]   inv_q;
    logic [WAY_W-1:0]  vict_q;
    logic [LINE_W-1:0] fill_q;

    logic [WAYS-1:0]   val_q   [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [WAY_W-1:0]  rr_q    [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];

    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  chk_idx;
    logic              chk_done, chk_step;
    logic [WAY_W-1:0]  vict_w;
    logic [LINE_W-1:0] base_line, merged_line;
    logic              merge_en;

    // tag compare on the latched request
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = val_q[rq.set][w] && (tag_q[rq.set][w] == rq.tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit = |hit_vec;
    end

    assign chk_idx  = chk_cnt_q[WAY_W-1:0];
    assign chk_done = (chk_cnt_q == (WAY_W+1)'(WAYS));
    assign chk_step = !chk_done &&
                      (st_q == ST_RDREQ || st_q == ST_RDWAIT || st_q == ST_CHECK);

    alloc_llc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .line_ok (val_q[rq.set]),
        .dead    (inv_q),
        .start   (rr_q[rq.set]),
        .pick    (vict_w)
    );

    always_comb begin
        if (st_q == ST_LOOK) base_line = data_q[rq.set][hit_way];
        else if (install_q)  base_line = '0;
        else                 base_line = fill_q;
    end
    assign merge_en = rq.we && (st_q == ST_LOOK || st_q == ST_FILL);

    alloc_llc_merge #(.DATA_W(DATA_W), .WORDS(WORDS), .WIDX_W(WIDX_W)) u_merge (
        .base   (base_line),
        .en     (merge_en),
        .widx   (rq.widx),
        .wdata  (rq.wdata),
        .be     (rq.be),
        .merged (merged_line)
    );

    // port outputs
    always_comb begin
        cpu_ready    = (st_q == ST_IDLE);
        cpu_rvalid   = (st_q == ST_LOOK && hit) || (st_q == ST_FILL);
        cpu_rdata    = base_line[rq.widx*DATA_W +: DATA_W];
        mem_valid    = (st_q == ST_RDREQ) || (st_q == ST_WB);
        mem_we       = (st_q == ST_WB);
        mem_addr     = (st_q == ST_WB) ? {tag_q[rq.set][vict_q], rq.set} : {rq.tag, rq.set};
        mem_wdata    = data_q[rq.set][vict_q];
        rng_qvalid   = (st_q == ST_LOOK && !hit) || chk_step;
        rng_qaddr    = (st_q == ST_LOOK) ? {rq.tag, rq.set} : {tag_q[rq.set][chk_idx], rq.set};
        rng_st_valid = (st_q == ST_FILL) && install_q;
        rng_st_addr  = {rq.tag, rq.set};
    end

    // control state
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            install_q <= 1'b0;
            chk_cnt_q <= '0;
            inv_q     <= '0;
            vict_q    <= '0;
            for (int s = 0; s < SETS; s++) begin
                val_q[s]   <= '0;
                dirty_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            if (chk_step) begin
                inv_q[chk_idx] <= rng_qhit;
                chk_cnt_q      <= chk_cnt_q + 1'b1;
            end
            unique case (st_q)
                ST_IDLE: if (cpu_valid) begin
                    install_q <= 1'b0;
                    st_q      <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (hit) begin
                        if (rq.we) dirty_q[rq.set][hit_way] <= 1'b1;
                        st_q <= ST_IDLE;
                    end else begin
                        install_q <= rq.we && rng_qhit;
                        chk_cnt_q <= '0;
                        inv_q     <= '0;
                        st_q      <= (rq.we && rng_qhit) ? ST_CHECK : ST_RDREQ;
                    end
                end
                ST_RDREQ:  if (mem_ready) st_q <= ST_RDWAIT;
                ST_RDWAIT: if (mem_rvalid) st_q <= ST_CHECK;
                ST_CHECK: if (chk_done) begin
                    vict_q <= vict_w;
                    if (val_q[rq.set][vict_w] && dirty_q[rq.set][vict_w] && !inv_q[vict_w])
                        st_q <= ST_WB;
                    else
                        st_q <= ST_FILL;
                end
                ST_WB: if (mem_ready) st_q <= ST_FILL;
                ST_FILL: begin
                    val_q[rq.set][vict_q]   <= 1'b1;
                    dirty_q[rq.set][vict_q] <= rq.we;
                    rr_q[rq.set]            <= vict_q + 1'b1;
                    st_q                    <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // request latch, fill buffer and arrays (no reset needed)
    always_ff @(posedge clk) begin
        if (st_q == ST_IDLE && cpu_valid) begin
            rq.we    <= cpu_we;
            rq.tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            rq.set   <= cpu_addr[OFF_W +: SET_W];
            rq.widx  <= cpu_addr[BOFF_W +: WIDX_W];
            rq.wdata <= cpu_wdata;
            rq.be    <= cpu_be;
        end
        if (st_q == ST_RDWAIT && mem_rvalid) fill_q <= mem_rdata;
        if (st_q == ST_LOOK && hit && rq.we) data_q[rq.set][hit_way] <= merged_line;
        if (st_q == ST_FILL) begin
            data_q[rq.set][vict_q] <= merged_line;
            tag_q[rq.set][vict_q]  <= rq.tag;
        end
    end
endmodule

// File: rtl/alloc_llc_chk.sv
module alloc_llc_chk #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int LA_W  = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_ready,
    input logic             cpu_rvalid,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_we,
    input logic [LA_W-1:0]  mem_addr,
    input logic             rng_st_valid,
    input logic             install_q,
    input logic [WAYS-1:0]  inv_q,
    input logic [WAY_W-1:0] vict_q,
    input logic [WAY_W-1:0] vict_w,
    input logic             chk_fin,
    input logic             all_valid
);
    // R4: an installing miss never issues a memory read
    a_r4_install_no_read: assert property (@(posedge clk) disable iff (rst)
        install_q |-> !(mem_valid && !mem_we));

    // R8: a write-back never targets a line found dead
    a_r8_dead_wb_dropped: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we) |-> !inv_q[vict_q]);

    // R9: with a full set, a dead candidate wins over live ones
    a_r9_dead_first: assert property (@(posedge clk) disable iff (rst)
        (chk_fin && all_valid && (|inv_q)) |-> inv_q[vict_w]);

    // R10: busy while memory or a response is in flight
    a_r10_busy_mem: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !cpu_ready);
    a_r10_busy_rsp: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> !cpu_ready);

    // R11: memory request held until accepted
    a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R12: trim notice only with the response of an installing store
    a_r12_trim_with_rsp: assert property (@(posedge clk) disable iff (rst)
        rng_st_valid |-> (cpu_rvalid && install_q));
endmodule

bind alloc_llc alloc_llc_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .LA_W(LA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_ready    (cpu_ready),
    .cpu_rvalid   (cpu_rvalid),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .rng_st_valid (rng_st_valid),
    .install_q    (install_q),
    .inv_q        (inv_q),
    .vict_q       (vict_q),
    .vict_w       (vict_w),
    .chk_fin      ((st_q == alloc_llc_pkg::ST_CHECK) && chk_done),
    .all_valid    (&val_q[rq.set])
);

// File: tb/tb_alloc_llc.sv
module tb_alloc_llc;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic         cpu_ready, cpu_rvalid;
    logic [31:0]  cpu_rdata;
    logic         mem_valid, mem_we;
    logic         mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         rng_qvalid, rng_qhit, rng_st_valid;
    logic [11:0]  rng_qaddr, rng_st_addr;

    logic [11:0]  rlo = '0, rhi = '0;
    int n_chk = 0, n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0, st_cnt = 0, phase = 0, rsp_wait = 0;
    logic [11:0]  pend_addr = '0, last_wr_addr = '0, st_last = '0;
    logic [127:0] last_wr_data = '0;
    logic [127:0] mem_store [int];

    bit          q_chk [$];
    logic [31:0] q_exp [$];
    string       q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alloc_llc dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rng_qvalid(rng_qvalid), .rng_qaddr(rng_qaddr), .rng_qhit(rng_qhit),
        .rng_st_valid(rng_st_valid), .rng_st_addr(rng_st_addr)
    );

    // range tracker model: [rlo, rhi) line addresses are dead
    always_comb rng_qhit = rng_qvalid && (rng_qaddr >= rlo) && (rng_qaddr < rhi);

    function automatic logic [31:0] defw(input logic [15:0] a);
        return {a[15:4], 2'b00, a[3:2], 16'hC0DE};
    endfunction

    function automatic logic [127:0] defline(input logic [11:0] la);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = {la, 4'(w), 16'hC0DE};
        return l;
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            mem_rvalid = 1'b0;
            mem_ready  = 1'b0;
        end else begin
            mem_rvalid = 1'b0;
            if (rsp_wait > 0) begin
                rsp_wait--;
                if (rsp_wait == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_store.exists(int'(pend_addr)) ? mem_store[int'(pend_addr)]
                                                                   : defline(pend_addr);
                end
            end
            phase++;
            mem_ready = (phase % 3) != 0;
            if (mem_valid && mem_ready) begin
                if (mem_we) begin
                    mem_store[int'(mem_addr)] = mem_wdata;
                    wr_cnt++;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end else begin
                    rd_cnt++;
                    pend_addr = mem_addr;
                    rsp_wait  = 3;
                end
            end
        end
    end

    // monitor: responses against the scoreboard, trim notices
    always @(negedge clk) begin
        if (!rst && cpu_rvalid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R2 unexpected response", 128'(cpu_rdata), 128'(0));
            end else begin
                if (q_chk[0])
                    check(cpu_rdata === q_exp[0], q_tag[0], 128'(cpu_rdata), 128'(q_exp[0]));
                void'(q_chk.pop_front());
                void'(q_exp.pop_front());
                void'(q_tag.pop_front());
            end
        end
        if (!rst && rng_st_valid) begin
            st_cnt++;
            st_last = rng_st_addr;
        end
    end

    // driver: one request, expected result queued first
    task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] be, input logic [31:0] exp, input string tag);
        q_chk.push_back(!we);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        @(negedge clk);
        cpu_valid = 1'b0;
        // R10: busy right after acceptance
        check(cpu_ready == 1'b0 || q_exp.size() == 0, "R10 ready low after accept",
              128'(cpu_ready), 128'(0));
        while (q_exp.size() != 0) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] a, input logic [31:0] exp, input string tag);
        access(1'b0, a, '0, '0, exp, tag);
    endtask

    task automatic store(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        access(1'b1, a, d, be, '0, "store");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (LIMIT) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", LIMIT, LIMIT);
        summary();
    end

    initial begin : stimulus
        int rd0, wr0;
        logic [31:0] w2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cpu_ready == 1'b1, "R1 ready after reset", 128'(cpu_ready), 128'(1));
        check(mem_valid == 1'b0, "R1 no memory request", 128'(mem_valid), 128'(0));
        check(cpu_rvalid == 1'b0, "R1 no response", 128'(cpu_rvalid), 128'(0));

        // R6 load miss (also R1: cache starts empty)
        rd0 = rd_cnt;
        load(16'h0104, defw(16'h0104), "R6 load miss data");
        check(rd_cnt == rd0 + 1, "R1 R6 first access reads memory", 128'(rd_cnt), 128'(rd0 + 1));

        // R2 load hit
        rd0 = rd_cnt;
        load(16'h0108, defw(16'h0108), "R2 load hit data");
        check(rd_cnt == rd0, "R2 hit has no memory read", 128'(rd_cnt), 128'(rd0));

        // R3 store hit with byte enables 0101
        w2 = mrg(defw(16'h0108), 32'hAABBCCDD, 4'b0101);
        store(16'h0108, 32'hAABBCCDD, 4'b0101);
        load(16'h0108, w2, "R3 byte merge");
        check(rd_cnt == rd0, "R3 store hit has no memory read", 128'(rd_cnt), 128'(rd0));

        // R4 R12 install into dead range [0x200,0x210)
        rlo = 12'h200; rhi = 12'h210;
        rd0 = rd_cnt;
        store(16'h2004, 32'h11223344, 4'b1111);
        check(rd_cnt == rd0, "R4 install without read", 128'(rd_cnt), 128'(rd0));
        check(st_cnt == 1 && st_last == 12'h200, "R12 trim notice address",
              {st_cnt[15:0], 4'h0, st_last}, {16'd1, 4'h0, 12'h200});
        load(16'h2004, 32'h11223344, "R4 stored word");
        load(16'h2008, 32'h0, "R4 zero filled word");
        check(rd_cnt == rd0, "R4 line valid after install", 128'(rd_cnt), 128'(rd0));

        // R9 R8 dead dirty line chosen and dropped
        rd0 = rd_cnt; wr0 = wr_cnt;
        load(16'h0304, defw(16'h0304), "R6 load miss data");
        check(wr_cnt == wr0, "R8 dead dirty victim not written", 128'(wr_cnt), 128'(wr0));
        check(rd_cnt == rd0 + 1, "R6 load miss reads", 128'(rd_cnt), 128'(rd0 + 1));
        load(16'h0108, w2, "R9 live line kept");
        check(rd_cnt == rd0 + 1, "R9 live line still cached", 128'(rd_cnt), 128'(rd0 + 1));

        // R5 R7 store miss outside range, round-robin evicts dirty live line
        rd0 = rd_cnt; wr0 = wr_cnt;
        store(16'h0404, 32'h0000BEEF, 4'b0011);
        check(rd_cnt == rd0 + 1, "R5 store miss reads memory", 128'(rd_cnt), 128'(rd0 + 1));
        check(wr_cnt == wr0 + 1, "R7 dirty live victim written", 128'(wr_cnt), 128'(wr0 + 1));
        check(last_wr_addr == 12'h010, "R7 write-back address", 128'(last_wr_addr), 128'(12'h010));
        check(last_wr_data[64 +: 32] == w2, "R7 write-back data", 128'(last_wr_data[64 +: 32]), 128'(w2));
        load(16'h0404, mrg(defw(16'h0404), 32'h0000BEEF, 4'b0011), "R5 merged word");
        load(16'h0408, defw(16'h0408), "R5 untouched word from memory");

        // R7 clean victim, no write
        wr0 = wr_cnt;
        load(16'h0504, defw(16'h0504), "R6 load miss data");
        check(wr_cnt == wr0, "R7 clean victim not written", 128'(wr_cnt), 128'(wr0));

        // R7 reload written-back line
        load(16'h0108, w2, "R7 reload after write-back");
        check(wr_cnt == wr0 + 1, "R7 dirty 0x040 written", 128'(wr_cnt), 128'(wr0 + 1));

        // R6 load miss inside dead range still reads
        rd0 = rd_cnt;
        rlo = 12'h200; rhi = 12'h210;
        load(16'h2044, defw(16'h2044), "R6 dead-range load data");
        check(rd_cnt == rd0 + 1, "R6 dead-range load reads", 128'(rd_cnt), 128'(rd0 + 1));

        // R8 line becomes dead after being dirtied
        store(16'h0108, 32'h99999999, 4'b1111);
        rlo = 12'h000; rhi = 12'h020;
        wr0 = wr_cnt;
        load(16'h0704, defw(16'h0704), "R6 load miss data");
        check(wr_cnt == wr0, "R8 dropped write-back", 128'(wr_cnt), 128'(wr0));
        rlo = 12'h000; rhi = 12'h000;
        load(16'h0108, w2, "R8 memory kept older value");

        // R2 other set
        load(16'h0614, defw(16'h0614), "R6 load miss set 1");
        load(16'h0618, defw(16'h0618), "R2 hit set 1");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule